// File: doc/BRIEF.md
# SPI Controller Interrupt Aggregator

This block gathers the condition signals of an SPI controller's FIFO and transfer logic into one level-sensitive interrupt line. Three registers sit on a 32-bit register bus: a global interrupt enable, an interrupt status register and a per-source interrupt enable. Each event input sets its own status bit. Software chooses which status bits may raise the interrupt, and it can switch the whole output off with one master bit.

The status register is written by exclusive-OR. Writing a 1 to a bit that is set clears that bit. Writing a 1 to a bit that is clear sets it. Two inputs, RX not-empty and RX full, are levels. Their status bits are set again on every cycle that the level stays high, so software cannot clear them while the condition holds. The other inputs are single-cycle strobes.

Reads have no side effects, so the bus has no read strobe. `reg_rdata` follows `reg_addr` combinationally. Writes take effect at the rising clock edge on which `reg_wr` is high. This interface carries register traffic only. It has no streaming data, so it has no valid/ready handshake and never applies back-pressure.

Top module: `spi_irq_agg`

## Requirements
- R1: After reset, the global enable register, the status register and the enable register all read 0, and `irq` is low.
- R2: The register offsets are fixed. Global enable is at byte offset 0x1C, and only its bit 31 is stored. Status is at 0x20. Enable is at 0x28, and only the implemented status bit positions are stored. Any other offset reads 0.
- R3: The event inputs map to status bits as follows: TX empty to bit 2, TX underrun to bit 3, RX full to bit 4, RX overrun to bit 5, TX half-empty to bit 6, and RX not-empty to bit 8. An input that is high at a clock edge sets its bit at that edge.
- R4: A write to the status register XORs the write data into the stored bits. A 1 written to a set bit clears it. A 1 written to a clear bit sets it.
- R5: When a hardware event and a software write both target the same status bit at the same edge, the hardware event wins and the bit ends up set.
- R6: While `ev_rx_not_empty` (bit 8) or `ev_rx_full` (bit 4) is held high, writing a 1 to that bit leaves it reading 1 afterwards.
- R7: `irq` is registered. It goes high one clock after some status bit and its matching enable bit are both 1 while global enable bit 31 is 1. It stays low when the pending bits are not enabled.
- R8: Clearing global enable bit 31 drives `irq` low one clock after the write, even while enabled status bits stay pending.
- R9: Status bit positions other than 2, 3, 4, 5, 6 and 8 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ev_tx_empty | input | 1 | TX data register empty strobe |
| ev_tx_underrun | input | 1 | TX underrun strobe |
| ev_rx_full | input | 1 | RX FIFO full level |
| ev_rx_overrun | input | 1 | RX overrun strobe |
| ev_tx_half_empty | input | 1 | TX FIFO half-empty strobe |
| ev_rx_not_empty | input | 1 | RX FIFO not-empty level |
| irq | output | 1 | Level interrupt output |

## Verification
A register write or an event lands at the rising edge it is presented on. Because reads are combinational, the new value can be read back in the low phase just after that edge. The interrupt output is one register later. The bench checks `irq` at the falling edge just after the causing edge and expects the old level there. It then checks again one falling edge later and expects the new level. All inputs are driven and all outputs sampled on falling edges, away from the active edge. For the hardware-wins case, the event and the write are presented together in the same cycle.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_GIE = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STS = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_ENA = 8'h28;

  localparam int BIT_GIE           = 31;
  localparam int BIT_TX_EMPTY      = 2;
  localparam int BIT_TX_UNDERRUN   = 3;
  localparam int BIT_RX_FULL       = 4;
  localparam int BIT_RX_OVERRUN    = 5;
  localparam int BIT_TX_HALF_EMPTY = 6;
  localparam int BIT_RX_NOT_EMPTY  = 8;

  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << BIT_TX_EMPTY)    | (REG_W'(1) << BIT_TX_UNDERRUN) |
      (REG_W'(1) << BIT_RX_FULL)     | (REG_W'(1) << BIT_RX_OVERRUN)  |
      (REG_W'(1) << BIT_TX_HALF_EMPTY) | (REG_W'(1) << BIT_RX_NOT_EMPTY);

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_GIE,
    SEL_STS,
    SEL_ENA
  } reg_sel_e;
endpackage

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int             DATA_W = REG_W,
  parameter logic [DATA_W-1:0] MASK = IMPL_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sts_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] set_vec,
  output logic [DATA_W-1:0] sts_q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      logic bit_q;
      logic tog;
      assign tog = sts_wr & wdata[i];
      // Hardware set takes priority over a same-cycle software toggle.
      always_ff @(posedge clk) begin
        if (rst) bit_q <= 1'b0;
        else     bit_q <= (bit_q ^ tog) | set_vec[i];
      end
      assign sts_q[i] = bit_q;

      p_hw_set_r3: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> sts_q[i]);
      p_toggle_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && wdata[i] && sts_q[i] && !set_vec[i]) |=> !sts_q[i]);
      p_hw_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && wdata[i] && sts_q[i] && set_vec[i]) |=> sts_q[i]);
    end else begin : g_none
      assign sts_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/spi_irq_regbus.sv
module spi_irq_regbus
  import spi_irq_pkg::*;
#(
  parameter int             DATA_W = REG_W,
  parameter int             AW     = ADDR_W,
  parameter logic [DATA_W-1:0] MASK = IMPL_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] sts_q,
  output logic              sts_wr,
  output logic              gie_q,
  output logic [DATA_W-1:0] ena_q,
  output logic [DATA_W-1:0] rdata
);
  reg_sel_e sel;

  always_comb begin
    unique case (addr)
      OFS_GIE: sel = SEL_GIE;
      OFS_STS: sel = SEL_STS;
      OFS_ENA: sel = SEL_ENA;
      default: sel = SEL_NONE;
    endcase
  end

  assign sts_wr = wr && (sel == SEL_STS);

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q <= 1'b0;
      ena_q <= '0;
    end else if (wr) begin
      if (sel == SEL_GIE) gie_q <= wdata[BIT_GIE];
      if (sel == SEL_ENA) ena_q <= wdata & MASK;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_GIE: rdata[BIT_GIE] = gie_q;
      SEL_STS: rdata = sts_q;
      SEL_ENA: rdata = ena_q;
      default: rdata = '0;
    endcase
  end

  p_gie_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_GIE) |=> $stable(gie_q));
  p_ena_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr && sel == SEL_ENA) |=> $stable(ena_q));
endmodule

// File: rtl/spi_irq_out.sv
module spi_irq_out
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sts_q,
  input  logic [DATA_W-1:0] ena_q,
  input  logic              gie_q,
  output logic              irq_q
);
  logic pending;
  assign pending = |(sts_q & ena_q);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= pending & gie_q;
  end

  p_gie_off_r8: assert property (@(posedge clk) disable iff (rst)
    !gie_q |=> !irq_q);
  p_no_enable_r7: assert property (@(posedge clk) disable iff (rst)
    (ena_q == '0) |=> !irq_q);
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int AW     = ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_tx_empty,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_full,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_half_empty,
  input  logic              ev_rx_not_empty,
  output logic              irq
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(IMPL_MASK);

  logic [DATA_W-1:0] set_vec;
  logic [DATA_W-1:0] sts_q;
  logic [DATA_W-1:0] ena_q;
  logic              gie_q;
  logic              sts_wr;

  always_comb begin
    set_vec = '0;
    set_vec[BIT_TX_EMPTY]      = ev_tx_empty;
    set_vec[BIT_TX_UNDERRUN]   = ev_tx_underrun;
    set_vec[BIT_RX_FULL]       = ev_rx_full;
    set_vec[BIT_RX_OVERRUN]    = ev_rx_overrun;
    set_vec[BIT_TX_HALF_EMPTY] = ev_tx_half_empty;
    set_vec[BIT_RX_NOT_EMPTY]  = ev_rx_not_empty;
  end

  spi_irq_regbus #(.DATA_W(DATA_W), .AW(AW), .MASK(MASK)) u_regbus (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .sts_q(sts_q), .sts_wr(sts_wr), .gie_q(gie_q), .ena_q(ena_q),
    .rdata(reg_rdata)
  );

  spi_irq_status #(.DATA_W(DATA_W), .MASK(MASK)) u_status (
    .clk(clk), .rst(rst), .sts_wr(sts_wr), .wdata(reg_wdata),
    .set_vec(set_vec), .sts_q(sts_q)
  );

  spi_irq_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .sts_q(sts_q), .ena_q(ena_q), .gie_q(gie_q),
    .irq_q(irq)
  );

  p_level_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ev_rx_not_empty |=> sts_q[BIT_RX_NOT_EMPTY]);
  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (sts_q & ~MASK) == '0);
endmodule

// File: tb/spi_irq_agg_tb.sv
module spi_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  ev = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  localparam logic [7:0] A_GIE = 8'h1C, A_STS = 8'h20, A_ENA = 8'h28;

  always #10 clk = ~clk;

  spi_irq_agg dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_tx_empty(ev[0]), .ev_tx_underrun(ev[1]), .ev_rx_full(ev[2]),
    .ev_rx_overrun(ev[3]), .ev_tx_half_empty(ev[4]), .ev_rx_not_empty(ev[5]),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); ev[idx] = 1'b1;
    @(negedge clk); ev[idx] = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 gie", A_GIE, 32'h0);
    rd_chk("R1 status", A_STS, 32'h0);
    rd_chk("R1 enable", A_ENA, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs;
    wr_reg(A_ENA, 32'hFFFF_FFFF);
    rd_chk("R2 enable mask", A_ENA, 32'h0000_017C);
    wr_reg(A_GIE, 32'hFFFF_FFFF);
    rd_chk("R2 gie bit31", A_GIE, 32'h8000_0000);
    rd_chk("R2 unmapped", 8'h24, 32'h0);
    wr_reg(A_ENA, 32'h0);
    wr_reg(A_GIE, 32'h0);
    rd_chk("R2 enable cleared", A_ENA, 32'h0);
  endtask

  task automatic t_events;
    int pos [6] = '{2, 3, 4, 5, 6, 8};
    for (int k = 0; k < 6; k++) begin
      pulse(k);
      rd_chk($sformatf("R3 event %0d sets bit %0d", k, pos[k]), A_STS, 32'h1 << pos[k]);
      wr_reg(A_STS, 32'h1 << pos[k]);
      rd_chk("R4 write-one clears", A_STS, 32'h0);
    end
  endtask

  task automatic t_xor;
    wr_reg(A_STS, 32'h8);
    rd_chk("R4 write-one sets clear bit", A_STS, 32'h8);
    wr_reg(A_STS, 32'h8);
    rd_chk("R4 second toggle clears", A_STS, 32'h0);
    wr_reg(A_STS, 32'hFFFF_FFFF);
    rd_chk("R9 unimplemented bits read 0", A_STS, 32'h0000_017C);
    wr_reg(A_STS, 32'h0000_017C);
    rd_chk("R9 back to zero", A_STS, 32'h0);
  endtask

  task automatic t_hw_wins;
    pulse(1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_STS; reg_wdata = 32'h8; ev[1] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev[1] = 1'b0;
    rd_chk("R5 hardware set wins", A_STS, 32'h8);
    wr_reg(A_STS, 32'h8);
    rd_chk("R5 cleared after", A_STS, 32'h0);
  endtask

  task automatic t_level;
    @(negedge clk); ev[5] = 1'b1; ev[2] = 1'b1;
    @(negedge clk);
    rd_chk("R6 levels set", A_STS, 32'h110);
    wr_reg(A_STS, 32'h110);
    rd_chk("R6 held levels resist clear", A_STS, 32'h110);
    ev[5] = 1'b0; ev[2] = 1'b0;
    wr_reg(A_STS, 32'h110);
    rd_chk("R6 cleared once released", A_STS, 32'h0);
  endtask

  task automatic t_irq;
    wr_reg(A_ENA, 32'h4);
    wr_reg(A_GIE, 32'h8000_0000);
    pulse(1);
    @(negedge clk);
    chk("R7 unenabled source no irq", {31'b0, irq}, 32'h0);
    wr_reg(A_ENA, 32'h8);
    chk("R7 irq one cycle late (old)", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R7 irq asserted", {31'b0, irq}, 32'h1);
    wr_reg(A_GIE, 32'h0);
    chk("R8 irq still high at write edge", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R8 gie off drops irq", {31'b0, irq}, 32'h0);
    wr_reg(A_GIE, 32'h8000_0000);
    @(negedge clk);
    chk("R7 irq back with gie", {31'b0, irq}, 32'h1);
    wr_reg(A_STS, 32'h8);
    @(negedge clk);
    chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_events();
    t_xor();
    t_hw_wins();
    t_level();
    t_irq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule